// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block gathers a bank of interrupt lines from peripherals and turns each one into a message that carries a vector number and a routing byte. The message goes to whatever fabric sits downstream. Software sets up each line through a 32-bit memory-mapped register port. Each line has a trigger mode (rising edge, falling edge, high level or low level), a mask, an enable for conversion to a message, and an entry in two byte-wide tables that hold its vector and its route.

Every line passes through a two-flop synchroniser. An edge-mode line latches a status bit when its selected transition is seen. A line that is pending, unmasked, enabled and not already in service competes for the single message output, and the lowest-numbered line wins. The output is a registered valid/ready channel. Once a message is accepted, its source is marked in service and sends nothing more until software writes a one to that line's bit in the clear register. That write also discards the line's latched edge status. If a level line is still active after the clear, it raises a fresh message.

Per-line bits are spread over 32-bit words: line n uses word n/32, bit n mod 32, and each further word sits 4 bytes above the one before it.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, and every enable, trigger-select, polarity and latched-status bit reads 0. msg_valid is low.
- R2: The word registers sit at these offsets: mask 0x20, message enable 0x40, trigger select 0x60, polarity 0x3E0. Line n lives in word n/32 (second word at +4), bit n mod 32. Writes honour the byte strobes, and the registers read back what was written. A read returns data on bus_rdata in the cycle after the request, flagged by bus_rvalid.
- R3: The route table is at 0x100+n and the vector table is at 0x200+n, one byte per line. A single byte write changes exactly one entry. A word read returns four entries, with line 4k+j in byte lane j.
- R4: The trigger-select bit and the polarity bit together set the mode of each line: (1,0) rising edge, (1,1) falling edge, (0,0) high level, (0,1) low level. An edge-mode line ignores the opposite transition and a steady level.
- R5: A selected edge, seen after the two-flop synchroniser, sets that line's latched status. Reading the clear offset (0x80 and 0x84) returns the latched status bits.
- R6: Writing 1 to a bit at the clear offset discards that line's latched status. Bits written as 0 leave their lines untouched.
- R7: A line whose mask bit is 1 sends no message. Clearing the mask bit of a line that is still pending lets its message out.
- R8: A line sends messages only while its enable bit is 1.
- R9: Each message carries the vector byte and the route byte programmed for its source line.
- R10: An accepted message puts its source in service, and the source sends nothing further. Writing 1 to the line's clear bit ends service, and a level line that is still active then sends again.
- R11: When several lines are eligible, the lowest-numbered line is sent first.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_vector and msg_route hold their values.
- R13: The two auxiliary words at 0xC0 and 0xE0 (each with a second word at +4) read back what was written and have no effect on message delivery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Asynchronous interrupt lines |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector byte of the source line |
| msg_route | output | 8 | Route byte of the source line |

## Verification
The assertions assume that the downstream side may hold msg_ready low for any number of cycles, and that the register port gets at most one access per cycle. They also assume each line's configuration changes only through the register port. They do not assume anything about when irq_in moves relative to the clock, because the synchroniser absorbs that. The bench drives irq_in and all bus signals on the falling edge. It holds every line steady for several cycles so the synchroniser sees each change. It only raises msg_ready while a message is being offered, and it writes every table entry before enabling a line, because the tables have no reset.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int unsigned BUS_AW    = 12;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned LANES     = WORD_BITS / 8;

  // Word register bases (each 32-line group adds 4 bytes)
  localparam logic [BUS_AW-1:0] OFS_MASK  = 12'h020;
  localparam logic [BUS_AW-1:0] OFS_MSGEN = 12'h040;
  localparam logic [BUS_AW-1:0] OFS_TRIG  = 12'h060;
  localparam logic [BUS_AW-1:0] OFS_CLR   = 12'h080;
  localparam logic [BUS_AW-1:0] OFS_AUXA  = 12'h0C0;
  localparam logic [BUS_AW-1:0] OFS_AUXB  = 12'h0E0;
  localparam logic [BUS_AW-1:0] OFS_POL   = 12'h3E0;

  // Byte table pages (address bits 11:8)
  localparam logic [3:0] PAGE_ROUTE = 4'h1;
  localparam logic [3:0] PAGE_VEC   = 4'h2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_MSGEN, SEL_TRIG, SEL_CLR, SEL_AUXA, SEL_AUXB, SEL_POL
  } wsel_e;
endpackage

// File: rtl/imc_sync.sv
module imc_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/imc_pend.sv
module imc_pend #(
  parameter int unsigned NUM_IN = 64,
  localparam int unsigned IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] trig_sel,
  input  logic [NUM_IN-1:0] pol_sel,
  input  logic [NUM_IN-1:0] clr_pulse,
  input  logic              fire,
  input  logic [IDX_W-1:0]  fire_idx,
  output logic [NUM_IN-1:0] pending,
  output logic [NUM_IN-1:0] edge_status,
  output logic [NUM_IN-1:0] inserv
);
  logic [NUM_IN-1:0] lvl_s;
  logic [NUM_IN-1:0] lvl_prev;

  imc_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      (irq_in),
    .q      (lvl_s),
    .q_prev (lvl_prev)
  );

  for (genvar n = 0; n < NUM_IN; n++) begin : g_line
    logic st_q;
    logic is_q;
    logic edge_hit;

    assign edge_hit = pol_sel[n] ? (~lvl_s[n] &  lvl_prev[n])
                                 : ( lvl_s[n] & ~lvl_prev[n]);

    // A fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                         st_q <= 1'b0;
      else if (trig_sel[n] && edge_hit) st_q <= 1'b1;
      else if (clr_pulse[n])           st_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)                                   is_q <= 1'b0;
      else if (fire && fire_idx == IDX_W'(n))    is_q <= 1'b1;
      else if (clr_pulse[n])                     is_q <= 1'b0;
    end

    assign edge_status[n] = st_q;
    assign inserv[n]      = is_q;
    assign pending[n]     = trig_sel[n] ? st_q : (lvl_s[n] ^ pol_sel[n]);
  end

  // Service marks appear only after an accepted message
  assert_service_after_send_R10: assert property (@(posedge clk) disable iff (rst)
    ((inserv & ~$past(inserv)) != '0) |-> $past(fire));

  // Status only latches for lines in an edge mode
  assert_status_edge_only_R4: assert property (@(posedge clk) disable iff (rst)
    ((edge_status & ~$past(edge_status) & ~$past(trig_sel)) == '0));
endmodule

// File: rtl/imc_arb.sv
module imc_arb #(
  parameter int unsigned NUM_IN = 64,
  localparam int unsigned IDX_W = $clog2(NUM_IN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IN-1:0]      eligible,
  input  logic [NUM_IN-1:0][7:0] route_tab,
  input  logic [NUM_IN-1:0][7:0] vec_tab,
  input  logic                   msg_ready,
  output logic                   msg_valid,
  output logic [7:0]             msg_vector,
  output logic [7:0]             msg_route,
  output logic [IDX_W-1:0]       cur_idx,
  output logic                   fire
);
  logic [IDX_W-1:0] win;
  logic             any;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        win = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign fire = msg_valid & msg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_route  <= '0;
      cur_idx    <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any) begin
      msg_valid  <= 1'b1;
      cur_idx    <= win;
      msg_vector <= vec_tab[win];
      msg_route  <= route_tab[win];
    end
  end

  assert_hold_until_ready_R12: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_route)));

  assert_gap_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !msg_valid);
endmodule

// File: rtl/imc_regs.sv
module imc_regs
  import imc_pkg::*;
#(
  parameter int unsigned NUM_IN = 64,
  localparam int unsigned IDX_W = $clog2(NUM_IN),
  localparam int unsigned WORDS = NUM_IN / WORD_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic [WORD_BITS-1:0]   bus_wdata,
  input  logic [LANES-1:0]       bus_wstrb,
  output logic                   bus_rvalid,
  output logic [WORD_BITS-1:0]   bus_rdata,
  input  logic [NUM_IN-1:0]      edge_status,
  output logic [NUM_IN-1:0]      mask,
  output logic [NUM_IN-1:0]      msg_en,
  output logic [NUM_IN-1:0]      trig_sel,
  output logic [NUM_IN-1:0]      pol_sel,
  output logic [NUM_IN-1:0]      clr_pulse,
  output logic [NUM_IN-1:0][7:0] route_tab,
  output logic [NUM_IN-1:0][7:0] vec_tab
);
  logic [NUM_IN-1:0]    aux_a;
  logic [NUM_IN-1:0]    aux_b;
  wsel_e                kind;
  logic [2:0]           widx;
  logic                 ent_ok;
  logic                 hit_route;
  logic                 hit_vec;
  logic [IDX_W-1:0]     ent_base;
  logic                 wr_en;
  logic                 rd_en;
  logic [WORD_BITS-1:0] rd_word;
  logic                 unused_lane_bits;

  assign wr_en            = bus_valid & bus_write;
  assign rd_en            = bus_valid & ~bus_write;
  assign widx             = bus_addr[4:2];
  assign unused_lane_bits = ^bus_addr[1:0];
  assign ent_ok           = (bus_addr[7:IDX_W] == '0);
  assign ent_base         = {bus_addr[IDX_W-1:2], 2'b00};
  assign hit_route        = (bus_addr[11:8] == PAGE_ROUTE) && ent_ok;
  assign hit_vec          = (bus_addr[11:8] == PAGE_VEC) && ent_ok;

  always_comb begin
    case ({bus_addr[11:5], 5'd0})
      OFS_MASK:  kind = SEL_MASK;
      OFS_MSGEN: kind = SEL_MSGEN;
      OFS_TRIG:  kind = SEL_TRIG;
      OFS_CLR:   kind = SEL_CLR;
      OFS_AUXA:  kind = SEL_AUXA;
      OFS_AUXB:  kind = SEL_AUXB;
      OFS_POL:   kind = SEL_POL;
      default:   kind = SEL_NONE;
    endcase
    if (widx >= 3'(WORDS)) kind = SEL_NONE;
  end

  function automatic logic [WORD_BITS-1:0] word_of(input logic [NUM_IN-1:0] v,
                                                   input logic [2:0] w);
    word_of = '0;
    for (int i = 0; i < WORDS; i++)
      if (w == 3'(i)) word_of = v[i*WORD_BITS +: WORD_BITS];
  endfunction

  // Word registers with byte strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '1;
      msg_en   <= '0;
      trig_sel <= '0;
      pol_sel  <= '0;
      aux_a    <= '0;
      aux_b    <= '0;
    end else if (wr_en && kind != SEL_NONE) begin
      for (int i = 0; i < WORDS; i++) begin
        for (int b = 0; b < LANES; b++) begin
          if (widx == 3'(i) && bus_wstrb[b]) begin
            case (kind)
              SEL_MASK:  mask    [i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              SEL_MSGEN: msg_en  [i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              SEL_TRIG:  trig_sel[i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              SEL_POL:   pol_sel [i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              SEL_AUXA:  aux_a   [i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              SEL_AUXB:  aux_b   [i*WORD_BITS + b*8 +: 8] <= bus_wdata[b*8 +: 8];
              default: ;
            endcase
          end
        end
      end
    end
  end

  // Byte tables: no reset, one byte per line
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (bus_wstrb[b]) begin
          if (hit_route) route_tab[ent_base + IDX_W'(b)] <= bus_wdata[b*8 +: 8];
          if (hit_vec)   vec_tab  [ent_base + IDX_W'(b)] <= bus_wdata[b*8 +: 8];
        end
      end
    end
  end

  // Write-one-to-clear strobe, one cycle wide
  always_comb begin
    clr_pulse = '0;
    if (wr_en && kind == SEL_CLR) begin
      for (int i = 0; i < WORDS; i++)
        for (int b = 0; b < LANES; b++)
          if (widx == 3'(i) && bus_wstrb[b])
            clr_pulse[i*WORD_BITS + b*8 +: 8] = bus_wdata[b*8 +: 8];
    end
  end

  always_comb begin
    case (kind)
      SEL_MASK:  rd_word = word_of(mask, widx);
      SEL_MSGEN: rd_word = word_of(msg_en, widx);
      SEL_TRIG:  rd_word = word_of(trig_sel, widx);
      SEL_CLR:   rd_word = word_of(edge_status, widx);
      SEL_AUXA:  rd_word = word_of(aux_a, widx);
      SEL_AUXB:  rd_word = word_of(aux_b, widx);
      SEL_POL:   rd_word = word_of(pol_sel, widx);
      default:   rd_word = '0;
    endcase
    for (int b = 0; b < LANES; b++) begin
      if (hit_route) rd_word[b*8 +: 8] = route_tab[ent_base + IDX_W'(b)];
      if (hit_vec)   rd_word[b*8 +: 8] = vec_tab[ent_base + IDX_W'(b)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_word;
    end
  end

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1 && msg_en == '0 && trig_sel == '0 && pol_sel == '0));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> bus_rvalid);
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import imc_pkg::*;
#(
  parameter int unsigned NUM_IN = 64,
  localparam int unsigned IDX_W = $clog2(NUM_IN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IN-1:0]    irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  input  logic [LANES-1:0]     bus_wstrb,
  output logic                 bus_rvalid,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_route
);
  logic [NUM_IN-1:0]      mask, msg_en, trig_sel, pol_sel, clr_pulse;
  logic [NUM_IN-1:0]      pending, edge_status, inserv, eligible, open_v;
  logic [NUM_IN-1:0][7:0] route_tab, vec_tab;
  logic [IDX_W-1:0]       cur_idx;
  logic                   fire;

  imc_regs #(.NUM_IN(NUM_IN)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wstrb   (bus_wstrb),
    .bus_rvalid  (bus_rvalid),
    .bus_rdata   (bus_rdata),
    .edge_status (edge_status),
    .mask        (mask),
    .msg_en      (msg_en),
    .trig_sel    (trig_sel),
    .pol_sel     (pol_sel),
    .clr_pulse   (clr_pulse),
    .route_tab   (route_tab),
    .vec_tab     (vec_tab)
  );

  imc_pend #(.NUM_IN(NUM_IN)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .irq_in      (irq_in),
    .trig_sel    (trig_sel),
    .pol_sel     (pol_sel),
    .clr_pulse   (clr_pulse),
    .fire        (fire),
    .fire_idx    (cur_idx),
    .pending     (pending),
    .edge_status (edge_status),
    .inserv      (inserv)
  );

  assign open_v   = ~mask & msg_en;
  assign eligible = pending & open_v & ~inserv;

  imc_arb #(.NUM_IN(NUM_IN)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .eligible   (eligible),
    .route_tab  (route_tab),
    .vec_tab    (vec_tab),
    .msg_ready  (msg_ready),
    .msg_valid  (msg_valid),
    .msg_vector (msg_vector),
    .msg_route  (msg_route),
    .cur_idx    (cur_idx),
    .fire       (fire)
  );

  // The line on offer is never one already in service
  assert_no_resend_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !inserv[cur_idx]);

  // A new offer comes only from a line that was unmasked and enabled
  assert_open_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> ((($past(open_v) >> cur_idx) & NUM_IN'(1)) != '0));
endmodule

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
  localparam int N = 64;
  localparam logic [11:0] A_MASK = 12'h020, A_EN = 12'h040, A_TRIG = 12'h060,
                          A_CLR = 12'h080, A_AUXA = 12'h0C0, A_AUXB = 12'h0E0,
                          A_POL = 12'h3E0;

  logic        clk = 1'b0;
  logic        rst;
  logic [N-1:0] irq_in;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        msg_valid, msg_ready;
  logic [7:0]  msg_vector, msg_route;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] sh_mask, sh_en, sh_trig, sh_pol;

  always #2 clk = ~clk;

  irq_msg_ctrl #(.NUM_IN(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_route(msg_route)
  );

  function automatic logic [7:0] rt(int n); return 8'(n ^ 'hA5); endfunction
  function automatic logic [7:0] vc(int n); return 8'(n + 'h10); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hxxxx_xxxx;
  endtask

  task automatic put64(logic [11:0] a, logic [N-1:0] v);
    wr(a, v[31:0]);
    wr(a + 12'd4, v[63:32]);
  endtask

  task automatic push_cfg();
    put64(A_TRIG, sh_trig);
    put64(A_POL, sh_pol);
    put64(A_EN, sh_en);
    put64(A_MASK, sh_mask);
  endtask

  task automatic clear_line(int n);
    wr(A_CLR + 12'(4 * (n / 32)), 32'(1) << (n % 32));
  endtask

  task automatic expect_none(string tag, int k);
    logic seen = 1'b0;
    repeat (k) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  task automatic expect_msg(string tag, int n);
    logic got = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (msg_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk({tag, " valid"}, 32'(got), 32'd1);
    chk({tag, " vector"}, 32'(msg_vector), 32'(vc(n)));
    chk({tag, " route"}, 32'(msg_route), 32'(rt(n)));
    if (got) begin
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic cleanup();
    sh_mask = '1; sh_en = '0; sh_trig = '0; sh_pol = '0;
    put64(A_MASK, sh_mask);
    put64(A_EN, sh_en);
    put64(A_TRIG, sh_trig);
    put64(A_POL, sh_pol);
    irq_in = '0;
    repeat (5) @(negedge clk);
    put64(A_CLR, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 msg_valid after reset", 32'(msg_valid), 32'd0);
    rd(A_MASK, d);         chk("R1 mask word0", d, 32'hFFFF_FFFF);
    rd(A_MASK + 12'd4, d); chk("R1 mask word1", d, 32'hFFFF_FFFF);
    rd(A_EN + 12'd4, d);   chk("R1 enable word1", d, 32'd0);
    rd(A_TRIG, d);         chk("R1 trigger word0", d, 32'd0);
    rd(A_POL + 12'd4, d);  chk("R1 polarity word1", d, 32'd0);
    rd(A_CLR, d);          chk("R1 status word0", d, 32'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    put64(A_MASK, 64'h0123_4567_89AB_CDEF);
    rd(A_MASK, d);         chk("R2 mask word0", d, 32'h89AB_CDEF);
    rd(A_MASK + 12'd4, d); chk("R2 mask word1", d, 32'h0123_4567);
    wr(A_MASK, 32'hAABB_CCDD, 4'b0100);
    rd(A_MASK, d);         chk("R2 byte strobe on mask", d, 32'h89BB_CDEF);
    put64(A_POL, 64'h8000_0001_0000_0000);
    rd(A_POL + 12'd4, d);  chk("R2 polarity word1", d, 32'h8000_0001);
    rd(A_POL, d);          chk("R2 polarity word0", d, 32'd0);
    put64(A_EN, 64'h0000_0000_F0F0_0000);
    rd(A_EN, d);           chk("R2 enable word0", d, 32'hF0F0_0000);
    cleanup();
  endtask

  task automatic t_tables();
    logic [31:0] d;
    for (int k = 0; k < N / 4; k++) begin
      logic [31:0] wr_route, wr_vec;
      for (int b = 0; b < 4; b++) begin
        wr_route[b*8 +: 8] = rt(4 * k + b);
        wr_vec[b*8 +: 8]   = vc(4 * k + b);
      end
      wr(12'h100 + 12'(4 * k), wr_route);
      wr(12'h200 + 12'(4 * k), wr_vec);
    end
    rd(12'h118, d); chk("R3 route word lines 24..27", d, {rt(27), rt(26), rt(25), rt(24)});
    wr(12'h105, 32'h0000_7700, 4'b0010);
    rd(12'h104, d); chk("R3 single byte route write", d, {rt(7), rt(6), 8'h77, rt(4)});
    wr(12'h105, {16'd0, rt(5), 8'd0}, 4'b0010);
    wr(12'h23E, 32'h0099_0000, 4'b0100);
    rd(12'h23C, d); chk("R3 single byte vector write", d, {vc(63), 8'h99, vc(61), vc(60)});
    wr(12'h23E, {8'd0, vc(62), 16'd0}, 4'b0100);
    rd(12'h23C, d); chk("R3 vector restore", d, {vc(63), vc(62), vc(61), vc(60)});
  endtask

  task automatic t_level_high();
    sh_en[3] = 1'b1; sh_mask[3] = 1'b0; push_cfg();
    expect_none("R4 level-high idle line quiet", 6);
    irq_in[3] = 1'b1;
    expect_msg("R9 level-high line 3", 3);
    expect_none("R10 no resend while in service", 8);
    clear_line(3);
    expect_msg("R10 still-active level resends after clear", 3);
    irq_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    clear_line(3);
    expect_none("R10 inactive level stays quiet after clear", 8);
    cleanup();
  endtask

  task automatic t_level_low();
    irq_in[7] = 1'b1;
    repeat (4) @(negedge clk);
    sh_pol[7] = 1'b1; sh_en[7] = 1'b1; sh_mask[7] = 1'b0; push_cfg();
    expect_none("R4 level-low line held high quiet", 6);
    irq_in[7] = 1'b0;
    expect_msg("R4 level-low line 7", 7);
    cleanup();
  endtask

  task automatic t_rising();
    logic [31:0] d;
    sh_trig[10] = 1'b1; sh_trig[11] = 1'b1; sh_en[10] = 1'b1; sh_en[11] = 1'b1;
    push_cfg();
    irq_in[10] = 1'b1; irq_in[11] = 1'b1;
    repeat (6) @(negedge clk);
    rd(A_CLR, d);  chk("R5 rising edges latched", d, 32'h0000_0C00);
    chk("R7 masked lines send nothing", 32'(msg_valid), 32'd0);
    wr(A_CLR, 32'h0000_0400);
    rd(A_CLR, d);  chk("R6 clear only the written-one bit", d, 32'h0000_0800);
    irq_in[10] = 1'b0; irq_in[11] = 1'b0;
    repeat (5) @(negedge clk);
    sh_mask[10] = 1'b0; put64(A_MASK, sh_mask);
    expect_none("R6 discarded edge sends nothing", 8);
    sh_mask[11] = 1'b0; put64(A_MASK, sh_mask);
    expect_msg("R7 unmask releases pending line 11", 11);
    clear_line(11);
    irq_in[10] = 1'b1;
    expect_msg("R4 rising edge line 10", 10);
    clear_line(10);
    expect_none("R4 held high after rise sends nothing", 8);
    irq_in[10] = 1'b0;
    expect_none("R4 fall ignored in rising mode", 8);
    cleanup();
  endtask

  task automatic t_falling();
    irq_in[40] = 1'b1;
    repeat (4) @(negedge clk);
    sh_trig[40] = 1'b1; sh_pol[40] = 1'b1; sh_en[40] = 1'b1; sh_mask[40] = 1'b0;
    push_cfg();
    expect_none("R4 falling mode steady high quiet", 6);
    irq_in[40] = 1'b0;
    expect_msg("R4 falling edge line 40", 40);
    cleanup();
  endtask

  task automatic t_enable();
    sh_mask[20] = 1'b0; push_cfg();
    irq_in[20] = 1'b1;
    expect_none("R8 disabled line sends nothing", 8);
    sh_en[20] = 1'b1; put64(A_EN, sh_en);
    expect_msg("R8 enabled line 20", 20);
    cleanup();
  endtask

  task automatic t_priority();
    logic [7:0] first_vec;
    logic       held_ok = 1'b1;
    sh_mask[33] = 1'b0; sh_mask[45] = 1'b0; sh_mask[60] = 1'b0; push_cfg();
    irq_in[33] = 1'b1; irq_in[45] = 1'b1; irq_in[60] = 1'b1;
    repeat (5) @(negedge clk);
    sh_en[33] = 1'b1; sh_en[45] = 1'b1; sh_en[60] = 1'b1;
    wr(A_EN + 12'd4, sh_en[63:32]);
    for (int i = 0; i < 8 && !msg_valid; i++) @(negedge clk);
    first_vec = msg_vector;
    chk("R11 lowest line first", 32'(first_vec), 32'(vc(33)));
    repeat (6) begin
      @(negedge clk);
      if (!msg_valid || msg_vector !== first_vec || msg_route !== rt(33)) held_ok = 1'b0;
    end
    chk("R12 offer held while ready low", 32'(held_ok), 32'd1);
    expect_msg("R11 first accepted", 33);
    expect_msg("R11 second in order", 45);
    expect_msg("R11 third in order", 60);
    cleanup();
  endtask

  task automatic t_aux();
    logic [31:0] d;
    wr(A_AUXA, 32'hDEAD_BEEF);
    wr(A_AUXB + 12'd4, 32'h5A5A_A5A5);
    rd(A_AUXA, d);         chk("R13 aux A readback", d, 32'hDEAD_BEEF);
    rd(A_AUXB + 12'd4, d); chk("R13 aux B readback", d, 32'h5A5A_A5A5);
    put64(A_AUXA, '1); put64(A_AUXB, '1);
    irq_in[2] = 1'b1;
    sh_en[2] = 1'b1; put64(A_EN, sh_en);
    expect_none("R13 aux words do not bypass mask", 6);
    sh_mask[2] = 1'b0; put64(A_MASK, sh_mask);
    expect_msg("R13 delivery unchanged with aux set", 2);
    put64(A_AUXA, '0); put64(A_AUXB, '0);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; irq_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wstrb = '0; msg_ready = 1'b0;
    sh_mask = '1; sh_en = '0; sh_trig = '0; sh_pol = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_tables();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_enable();
    t_priority();
    t_aux();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule